// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing core of a two-channel pulse-width modulator. It holds a 16-bit counter that advances once per prescaled tick. A two-stage prescaler divides the system clock to make that tick. The counter can count up, count down, count up then down, or hold its value. Downstream compare and action logic uses the counter value and two one-cycle event strobes. One strobe marks the counter at zero and the other marks the counter at the active period.

Software reaches the block through a small register port. Address 0 is the control word. A write to address 1 sets the period. Reads of address 1 return the last period written, and reads of address 2 return the active period that the counter uses. Address 3 reads as zero. One control bit picks where a period write lands:
- In shadow mode, the write goes to a holding register. That value is copied into the active period when the counter is at zero on a tick.
- In immediate mode, the write goes to the active period at once.

The counter is a small state machine with three direction states:
- ST_INC (counting up).
- ST_DEC (counting down).
- ST_HOLD (frozen).

The transitions are taken only on a tick:
- Up mode forces ST_INC, and down mode forces ST_DEC.
- Hold mode forces ST_HOLD.
- In up-down mode, ST_INC moves to ST_DEC when the count reaches the period.
- In up-down mode, ST_DEC moves to ST_INC when the count reaches zero.
- In up-down mode, ST_HOLD continues as ST_INC.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0 and the control word reads 0, which selects up mode, shadow loading and divide-by-1. Both the written period (address 1) and the active period (address 2) read 0xFFFF. Once reset is released, the counter advances by one on every clock.
- R2: A control write keeps only the counter-mode field (bits 1:0), the load-select bit (bit 3), the high-speed divider field (bits 9:7) and the low-speed divider field (bits 12:10). All other bits read back as 0.
- R3: Mode 00 is up mode. On each tick the counter increments, and it goes to 0 on the tick after it equals the active period P, giving the sequence 0,1,..,P,0.
- R4: Mode 01 is down mode. On each tick the counter decrements, and it reloads to the period on the tick after it is 0, giving the sequence P,..,1,0,P.
- R5: Mode 10 is up-down mode. The counter rises to P, then falls to 0, then rises again, giving the sequence 0,1,..,P,P-1,..,0,1.
- R6: Mode 11 is hold mode. The counter keeps its value and neither event strobe is asserted, even when the held value equals 0 or the period.
- R7: With low-speed field k and high-speed field h, the counter advances once every 2^k × (h = 0 ? 1 : 2h) clock cycles.
- R8: When bit 3 is 0, a period write changes only the written period. The active period takes that value on the clock after the counter is at 0 on a tick, and it does not change at any other time.
- R9: When bit 3 is 1, a period write updates both the active period and the written period on the next clock.
- R10: evt_zero is high only in a tick cycle in which the counter is 0, and evt_prd is high only in a tick cycle in which the counter equals the active period. When the prescale factor is greater than 1, each strobe therefore lasts exactly one clock per visit to that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 period, 2 active period, 3 none |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| cnt_o | output | 16 | Current counter value |
| evt_zero | output | 1 | Counter-at-zero event strobe |
| evt_prd | output | 1 | Counter-at-period event strobe |

## Verification
The hardest case to reach is the shadow load. The active period may change only when the counter is at zero on a tick, so the stimulus has to land a period write in the middle of a count cycle. To do this, the bench first sets a short period in immediate mode while the counter is held. It then switches to shadow mode and writes a new period once the counter is part-way up. It reads back both period registers before and after the zero crossing, and confirms that the wrap point moves only after that crossing. Strobe gating is tested by running a divided clock and counting how many clocks each strobe is high while the counter dwells on zero or on the period.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
    localparam int DEF_CNT_W = 16;
    localparam int DEF_LS_W  = 3;
    localparam int DEF_HS_W  = 3;

    // control-word field positions
    localparam int MODE_LSB = 0;
    localparam int LOAD_BIT = 3;
    localparam int HS_LSB   = 7;
    localparam int LS_LSB   = 10;

    typedef enum logic [1:0] {
        MODE_UP   = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UPDN = 2'b10,
        MODE_HOLD = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ST_INC  = 2'b00,
        ST_DEC  = 2'b01,
        ST_HOLD = 2'b10
    } dir_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_PRD  = 2'd1;
    localparam logic [1:0] ADDR_ACT  = 2'd2;
endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler
    import ptb_pkg::*;
#(
    parameter int LS_W = DEF_LS_W,
    parameter int HS_W = DEF_HS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LS_W-1:0] ls_div,
    input  logic [HS_W-1:0] hs_div,
    output logic            tick
);
    localparam int PS_W = HS_W + 1 + (2 ** LS_W) - 1;

    logic [HS_W:0]   hs_factor;
    logic [PS_W-1:0] factor;
    logic [PS_W-1:0] pc_q;

    always_comb begin
        hs_factor = (hs_div == '0) ? (HS_W+1)'(1) : {hs_div, 1'b0};
        factor    = PS_W'(hs_factor) << ls_div;
        tick      = (pc_q >= factor - PS_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc_q <= '0;
        else if (tick)
            pc_q <= '0;
        else
            pc_q <= pc_q + PS_W'(1);
    end
endmodule

// File: rtl/ptb_regs.sv
module ptb_regs
    import ptb_pkg::*;
#(
    parameter int W    = DEF_CNT_W,
    parameter int LS_W = DEF_LS_W,
    parameter int HS_W = DEF_HS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic         zero_evt,
    output logic [W-1:0] ctrl_q,
    output logic [W-1:0] prd_active,
    output logic [W-1:0] prd_next,
    output logic [W-1:0] shadow_o,
    output logic [W-1:0] rdata
);
    localparam int MASK_I = (((1 << LS_W) - 1) << LS_LSB)
                          | (((1 << HS_W) - 1) << HS_LSB)
                          | (1 << LOAD_BIT)
                          | (3 << MODE_LSB);
    localparam logic [W-1:0] CTRL_MASK = W'(MASK_I);

    logic [W-1:0] shadow_q;
    logic         imm_mode;
    logic         shadow_load;

    always_comb begin
        imm_mode    = ctrl_q[LOAD_BIT];
        shadow_load = zero_evt && !imm_mode;
        prd_next    = shadow_load ? shadow_q : prd_active;
        shadow_o    = shadow_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            shadow_q   <= '1;
            prd_active <= '1;
        end else begin
            if (we && addr == ADDR_CTRL)
                ctrl_q <= wdata & CTRL_MASK;
            if (we && addr == ADDR_PRD)
                shadow_q <= wdata;
            if (we && addr == ADDR_PRD && imm_mode)
                prd_active <= wdata;
            else if (shadow_load)
                prd_active <= shadow_q;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_CTRL: rdata = ctrl_q;
            ADDR_PRD:  rdata = shadow_q;
            ADDR_ACT:  rdata = prd_active;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
    import ptb_pkg::*;
#(
    parameter int W = DEF_CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] prd_next,
    input  logic [W-1:0] prd_act,
    output logic [W-1:0] cnt_o,
    output logic         at_zero,
    output logic         at_prd
);
    dir_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INC;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and next count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (tick) begin
            unique case (mode)
                MODE_HOLD: state_d = ST_HOLD;
                MODE_UP: begin
                    state_d = ST_INC;
                    cnt_d   = (cnt_q >= prd_next) ? '0 : cnt_q + W'(1);
                end
                MODE_DOWN: begin
                    state_d = ST_DEC;
                    cnt_d   = (cnt_q == '0 || cnt_q > prd_next) ? prd_next
                                                                : cnt_q - W'(1);
                end
                MODE_UPDN: begin
                    if (state_q == ST_DEC) begin
                        if (cnt_q == '0) begin
                            state_d = ST_INC;
                            cnt_d   = (prd_next == '0) ? '0 : W'(1);
                        end else begin
                            cnt_d = cnt_q - W'(1);
                        end
                    end else if (cnt_q >= prd_next) begin
                        if (cnt_q == '0) begin
                            state_d = ST_INC;
                        end else begin
                            state_d = ST_DEC;
                            cnt_d   = cnt_q - W'(1);
                        end
                    end else begin
                        state_d = ST_INC;
                        cnt_d   = cnt_q + W'(1);
                    end
                end
                default: state_d = state_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        cnt_o   = cnt_q;
        at_zero = tick && (mode != MODE_HOLD) && (cnt_q == '0);
        at_prd  = tick && (mode != MODE_HOLD) && (cnt_q == prd_act);
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int LS_W  = DEF_LS_W,
    parameter int HS_W  = DEF_HS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic             evt_zero,
    output logic             evt_prd
);
    logic [CNT_W-1:0] ctrl_q;
    logic [CNT_W-1:0] prd_active;
    logic [CNT_W-1:0] prd_next;
    logic [CNT_W-1:0] prd_shadow;
    logic             tick;
    cnt_mode_e        mode;

    always_comb mode = cnt_mode_e'(ctrl_q[MODE_LSB +: 2]);

    ptb_regs #(.W(CNT_W), .LS_W(LS_W), .HS_W(HS_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .zero_evt   (evt_zero),
        .ctrl_q     (ctrl_q),
        .prd_active (prd_active),
        .prd_next   (prd_next),
        .shadow_o   (prd_shadow),
        .rdata      (reg_rdata)
    );

    ptb_prescaler #(.LS_W(LS_W), .HS_W(HS_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .ls_div (ctrl_q[LS_LSB +: LS_W]),
        .hs_div (ctrl_q[HS_LSB +: HS_W]),
        .tick   (tick)
    );

    ptb_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode),
        .prd_next (prd_next),
        .prd_act  (prd_active),
        .cnt_o    (cnt_o),
        .at_zero  (evt_zero),
        .at_prd   (evt_prd)
    );
endmodule

// File: rtl/ptb_checker.sv
module ptb_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_we,
    input logic [1:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic [W-1:0] ctrl_q,
    input logic [W-1:0] prd_active,
    input logic [W-1:0] cnt_o,
    input logic         evt_zero,
    input logic         evt_prd
);
    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1:0] == 2'b11) |=> $stable(cnt_o));

    // R6
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1:0] == 2'b11) |-> (!evt_zero && !evt_prd));

    // R3
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1:0] == 2'b00 && evt_prd && cnt_o != '0) |=> (cnt_o == '0));

    // R4
    down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1:0] == 2'b01 && evt_zero && !(reg_we && reg_addr == 2'd1))
        |=> (cnt_o == prd_active));

    // R9
    imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd1 && ctrl_q[3]) |=> (prd_active == $past(reg_wdata)));

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[3] && !evt_zero) |=> $stable(prd_active));

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[12:7] != '0 && evt_zero && !reg_we) |=> !evt_zero);
endmodule

bind pwm_timebase ptb_checker #(.W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ctrl_q     (ctrl_q),
    .prd_active (prd_active),
    .cnt_o      (cnt_o),
    .evt_zero   (evt_zero),
    .evt_prd    (evt_prd)
);

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [15:0] cnt_o;
    logic        evt_zero;
    logic        evt_prd;

    int nchk = 0;
    int nerr = 0;

    localparam logic [15:0] M_UP   = 16'h0000;
    localparam logic [15:0] M_DN   = 16'h0001;
    localparam logic [15:0] M_UD   = 16'h0002;
    localparam logic [15:0] M_HOLD = 16'h0003;
    localparam logic [15:0] IMM    = 16'h0008;

    pwm_timebase u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cnt_o     (cnt_o),
        .evt_zero  (evt_zero),
        .evt_prd   (evt_prd)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] divw(input int k, input int h);
        return 16'((k << 10) | (h << 7));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        reg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wait_cnt(input int v, input string req);
        int n = 0;
        while (int'(cnt_o) != v && n < 4000) begin
            @(negedge clk);
            n++;
        end
        if (int'(cnt_o) != v) check(req, int'(cnt_o), v);
    endtask

    task automatic setup(input logic [15:0] p, input logic [15:0] mw);
        wr(2'd0, M_HOLD | IMM);
        wr(2'd1, p);
        wr(2'd0, mw);
    endtask

    task automatic t_reset();
        int v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 cnt in reset", int'(cnt_o), 0);
        rd(2'd0, v); check("R1 ctrl reset", v, 0);
        rd(2'd1, v); check("R1 period reset", v, 16'hFFFF);
        rd(2'd2, v); check("R1 active reset", v, 16'hFFFF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first count", int'(cnt_o), 1);
        @(negedge clk);
        check("R1 second count", int'(cnt_o), 2);
    endtask

    task automatic t_ctrl_mask();
        int v;
        do_reset();
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); check("R2 mask all ones", v, 16'h1F8B);
        wr(2'd0, 16'h1234);
        rd(2'd0, v); check("R2 mask pattern", v, 16'h1200);
    endtask

    task automatic t_up_and_hold();
        do_reset();
        setup(16'd4, M_UP | IMM);
        wait_cnt(0, "R3 reach zero");
        check("R3 zero strobe", int'(evt_zero), 1);
        check("R3 no prd strobe at zero", int'(evt_prd), 0);
        for (int i = 1; i <= 5; i++) begin
            int e = i % 5;
            @(negedge clk);
            check("R3 up count", int'(cnt_o), e);
            check("R3 prd strobe", int'(evt_prd), (e == 4) ? 1 : 0);
        end
        wait_cnt(3, "R6 reach 3");
        wr(2'd0, M_HOLD | IMM);
        for (int i = 0; i < 4; i++) begin
            check("R6 held value", int'(cnt_o), 4);
            check("R6 no strobe at period", int'(evt_prd), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_down();
        do_reset();
        setup(16'd3, M_DN | IMM);
        wait_cnt(0, "R4 reach zero");
        check("R4 zero strobe", int'(evt_zero), 1);
        for (int i = 0; i < 5; i++) begin
            int e = (i == 3) ? 0 : 3 - (i % 4);
            @(negedge clk);
            if (i == 4) e = 3;
            check("R4 down count", int'(cnt_o), e);
            check("R4 prd strobe", int'(evt_prd), (e == 3) ? 1 : 0);
        end
    endtask

    task automatic t_updown();
        int exp_seq [7] = '{1, 2, 3, 2, 1, 0, 1};
        do_reset();
        setup(16'd3, M_UD | IMM);
        wait_cnt(0, "R5 reach zero");
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            check("R5 updown count", int'(cnt_o), exp_seq[i]);
            check("R5 zero strobe", int'(evt_zero), (exp_seq[i] == 0) ? 1 : 0);
        end
    endtask

    task automatic t_prescale(input int k, input int h, input int f);
        int prev;
        int n;
        do_reset();
        wr(2'd0, M_UP | IMM | divw(k, h));
        prev = int'(cnt_o);
        n = 0;
        while (int'(cnt_o) == prev && n < 5000) begin @(negedge clk); n++; end
        for (int m = 0; m < 2; m++) begin
            prev = int'(cnt_o);
            n = 0;
            do begin @(negedge clk); n++; end while (int'(cnt_o) == prev && n < 5000);
            check("R7 tick interval", n, f);
        end
    endtask

    task automatic t_gating();
        int nz;
        int n;
        do_reset();
        setup(16'd2, M_UP | IMM | divw(2, 0));
        wait_cnt(0, "R10 reach zero");
        nz = 0; n = 0;
        while (int'(cnt_o) == 0 && n < 100) begin
            nz += int'(evt_zero); n++; @(negedge clk);
        end
        check("R10 zero dwell", n, 4);
        check("R10 zero strobe width", nz, 1);
        wait_cnt(2, "R10 reach period");
        nz = 0; n = 0;
        while (int'(cnt_o) == 2 && n < 100) begin
            nz += int'(evt_prd); n++; @(negedge clk);
        end
        check("R10 prd strobe width", nz, 1);
    endtask

    task automatic t_shadow();
        int v;
        do_reset();
        wr(2'd0, M_HOLD | IMM);
        wr(2'd1, 16'd5);
        wr(2'd0, M_UP);
        wait_cnt(2, "R8 reach 2");
        wr(2'd1, 16'd3);
        rd(2'd1, v); check("R8 written period", v, 3);
        rd(2'd2, v); check("R8 active unchanged", v, 5);
        wait_cnt(5, "R8 old period reached");
        wait_cnt(0, "R8 wrap");
        rd(2'd2, v); check("R8 active before load", v, 5);
        @(negedge clk);
        rd(2'd2, v); check("R8 active after load", v, 3);
        check("R8 count after load", int'(cnt_o), 1);
        @(negedge clk); check("R8 count", int'(cnt_o), 2);
        @(negedge clk); check("R8 count", int'(cnt_o), 3);
        @(negedge clk); check("R8 new wrap", int'(cnt_o), 0);
    endtask

    task automatic t_immediate();
        int v;
        do_reset();
        setup(16'd6, M_UP | IMM);
        wait_cnt(5, "R9 reach 5");
        wr(2'd1, 16'd2);
        check("R9 count", int'(cnt_o), 6);
        rd(2'd2, v); check("R9 active now", v, 2);
        rd(2'd1, v); check("R9 written", v, 2);
        @(negedge clk); check("R9 wrap", int'(cnt_o), 0);
        @(negedge clk); check("R9 count", int'(cnt_o), 1);
        @(negedge clk); check("R9 count", int'(cnt_o), 2);
        @(negedge clk); check("R9 short wrap", int'(cnt_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_ctrl_mask();
        t_up_and_hold();
        t_down();
        t_updown();
        t_prescale(0, 0, 1);
        t_prescale(2, 0, 4);
        t_prescale(0, 3, 6);
        t_prescale(1, 5, 20);
        t_prescale(3, 1, 16);
        t_gating();
        t_shadow();
        t_immediate();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule